// File: doc/BRIEF.md
# Packed Subword Multiply-Accumulate Unit

This block is the fixed-point multiply-accumulate datapath of one compute block. Each accepted beat carries two 32-bit operand words and a control word. The control word selects the lane split: one 32-bit lane, two 16-bit lanes, or four 8-bit lanes. It also selects signed or unsigned operands, integer or fractional format, saturating or wrapping accumulation, a clear, and an accumulate enable. Each lane multiplies its two subwords and adds the product into its own accumulator. The accumulators share one 80-bit store, which is split as 1x80, 2x40 or 4x20 bits. A second copy of the unit gives two-way SIMD operation.

The pipeline has two stages. Stage one registers the widened products. Stage two updates the accumulators. The input is a valid/ready stream. A beat is accepted in any cycle where `in_valid` and `in_ready` are both high. Result availability is signalled by `out_valid`, and `out_ready` gives back-pressure. While `out_valid` is high and `out_ready` is low, the whole pipeline holds and `in_ready` is low. When `out_ready` is high, or no result is pending, the pipeline advances every cycle and one beat can be accepted per cycle. The clear and enable of a beat act in the same stage as that beat's product. Changing lane mode while the accumulators hold data reinterprets the stored bits under the new split.

Top module: `smac_unit`

## Requirements
- R1: Mode code 0 gives one lane of 32 bits. Code 1 gives two lanes of 16 bits. Codes 2 and 3 both give four lanes of 8 bits. Lane l takes operand bits [l*W +: W] and uses accumulator bits [l*A +: A] of `acc_o`.
- R2: The accumulator width A is 80 bits for 32-bit lanes, 40 bits for 16-bit lanes and 20 bits for 8-bit lanes. Each product is extended to A bits before it is added.
- R3: With `in_signed` high, the operands and the accumulators are two's complement. With it low, they are unsigned.
- R4: In signed fractional format the product is doubled. In unsigned fractional format and in integer format the product is used unchanged.
- R5: In signed fractional format, minus one times minus one yields 2^(2W-1)-1 when saturation is on. It yields 2^(2W-1) when saturation is off.
- R6: With saturation on, an overflowing lane is clamped. A signed lane goes to 2^(A-1)-1 or -2^(A-1). An unsigned lane goes to 2^A-1.
- R7: With saturation off, an overflowing lane keeps its sum modulo 2^A.
- R8: `ovf_o[l]` is set when lane l overflows, with or without saturation. It stays set until a beat with clear is applied. Flags of lanes that are unused in the current mode are kept.
- R9: Clear zeroes the lane before the product is added. When accumulate enable is low, the product is ignored, so a beat without clear leaves the accumulators and flags unchanged.
- R10: A beat accepted in cycle i shows its updated accumulators, with `out_valid` high, in cycle i+2. In cycle i+1, `out_valid` is low unless an earlier beat was accepted.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `acc_o`, `ovf_o` and `out_valid` hold.
- R12: After reset, the accumulators and flags are zero, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| in_mode | input | 2 | Lane split code |
| in_signed | input | 1 | Signed operands and accumulators |
| in_frac | input | 1 | Fractional format |
| in_sat | input | 1 | Saturating accumulation |
| in_clr | input | 1 | Clear lanes and flags before adding |
| in_acc_en | input | 1 | Add the product |
| out_valid | output | 1 | Fresh result on the accumulator port |
| out_ready | input | 1 | Consumer takes the result |
| acc_o | output | 80 | Packed accumulators |
| ovf_o | output | 4 | Sticky per-lane overflow flags |

## Verification
The bench sweeps corner operands in every lane width under all signed, fractional and saturation combinations: zero, one, the most positive value, the most negative value and all ones. If the fractional doubling were misplaced, the products would be off by a factor of two. If the minus-one-squared clamp were missing, the product would show 2^(2W-1) where saturation is on. Long runs push 8-bit and 16-bit lanes past their accumulator range, signed and unsigned, with and without saturation. Wrong lane boundaries would then leak carries into a neighbour, and a wrong clamp would show wrapped values. Sticky flags are checked across later clean beats and after a clear. A stalled consumer is held for several cycles to catch an accumulator that moves or a beat that slips in during the stall.

// File: rtl/smac_pkg.sv
package smac_pkg;

  typedef enum logic [1:0] {
    MODE_W32   = 2'd0,
    MODE_W16   = 2'd1,
    MODE_W8    = 2'd2,
    MODE_W8ALT = 2'd3
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e mode;
    logic       sgn;
    logic       frac;
    logic       sat;
    logic       clr;
    logic       acc_en;
  } mac_ctrl_t;

  // lane-split index: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
  function automatic logic [1:0] split_idx(lane_mode_e m);
    case (m)
      MODE_W32: split_idx = 2'd0;
      MODE_W16: split_idx = 2'd1;
      default:  split_idx = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/smac_lane_mul.sv
module smac_lane_mul #(
  parameter int W  = 8,
  parameter int AW = 20
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sgn_i,
  input  logic          frac_i,
  input  logic          sat_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2*W + 2;
  localparam logic [PW-1:0] PEAK  = PW'(1) << (2*W - 1);
  localparam logic [AW-1:0] PEAKA = AW'(1) << (2*W - 1);

  logic [W:0]    ax, bx;
  logic [PW-1:0] raw, shaped;

  always_comb begin
    ax  = {sgn_i & a_i[W-1], a_i};
    bx  = {sgn_i & b_i[W-1], b_i};
    raw = $signed({{(W+1){ax[W]}}, ax}) * $signed({{(W+1){bx[W]}}, bx});
    shaped = (sgn_i && frac_i) ? (raw << 1) : raw;
    if (sgn_i && frac_i && sat_i && shaped == PEAK)
      shaped = PEAK - PW'(1);
    prod_o = {{(AW-PW){shaped[PW-1]}}, shaped};
  end

  // R5: the doubled minus-one square never escapes when clamping is requested
  always_comb begin
    if (sgn_i && frac_i && sat_i)
      assert_frac_clamp_R5: assert (prod_o != PEAKA);
  end

endmodule

// File: rtl/smac_lane_acc.sv
module smac_lane_acc #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] prod_i,
  input  logic          sgn_i,
  input  logic          sat_i,
  input  logic          clr_i,
  input  logic          add_i,
  output logic [AW-1:0] acc_o,
  output logic          ovf_o
);
  logic [AW-1:0] base;
  logic [AW:0]   sum;
  logic          over;
  logic [AW-1:0] clamp;

  always_comb begin
    base = clr_i ? '0 : acc_i;
    if (sgn_i) sum = {base[AW-1], base} + {prod_i[AW-1], prod_i};
    else       sum = {1'b0, base} + {1'b0, prod_i};
    over = sgn_i ? (sum[AW] ^ sum[AW-1]) : sum[AW];
    if (!sgn_i)      clamp = '1;
    else if (sum[AW]) clamp = {1'b1, {(AW-1){1'b0}}};
    else             clamp = {1'b0, {(AW-1){1'b1}}};
    if (!add_i) begin
      acc_o = base;
      ovf_o = 1'b0;
    end else begin
      acc_o = (over && sat_i) ? clamp : sum[AW-1:0];
      ovf_o = over;
    end
  end

  // R6: a saturating unsigned lane never decreases when it adds
  always_comb begin
    if (!sgn_i && sat_i && add_i && !clr_i)
      assert_unsigned_clamp_R6: assert (acc_o >= acc_i);
  end

endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int OPW    = 32,
  parameter int NSPLIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OPW-1:0]        in_a,
  input  logic [OPW-1:0]        in_b,
  input  logic [1:0]            in_mode,
  input  logic                  in_signed,
  input  logic                  in_frac,
  input  logic                  in_sat,
  input  logic                  in_clr,
  input  logic                  in_acc_en,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OPW*5/2-1:0]    acc_o,
  output logic [(1<<(NSPLIT-1))-1:0] ovf_o
);
  localparam int MAXL = 1 << (NSPLIT - 1);
  localparam int ACCW = OPW * 5 / 2;

  logic            advance;
  logic            s1_v, out_v;
  mac_ctrl_t       in_ctrl, s1_ctrl;
  logic [ACCW-1:0] s1_prod, acc_q;
  logic [MAXL-1:0] ovf_q;

  logic [ACCW-1:0] prod_all [NSPLIT];
  logic [ACCW-1:0] acc_all  [NSPLIT];
  logic [MAXL-1:0] ovf_all  [NSPLIT];
  logic [ACCW-1:0] prod_sel, acc_sel;
  logic [MAXL-1:0] ovf_sel;

  assign advance  = !out_v || out_ready;
  assign in_ready = advance;

  always_comb begin
    in_ctrl.mode   = lane_mode_e'(in_mode);
    in_ctrl.sgn    = in_signed;
    in_ctrl.frac   = in_frac;
    in_ctrl.sat    = in_sat;
    in_ctrl.clr    = in_clr;
    in_ctrl.acc_en = in_acc_en;
  end

  // one multiplier and one adder set per lane split
  for (genvar m = 0; m < NSPLIT; m++) begin : g_split
    localparam int NL = 1 << m;
    localparam int W  = OPW >> m;
    localparam int AW = ACCW >> m;
    logic [ACCW-1:0] prod_m, acc_m;
    logic [MAXL-1:0] ovf_m;
    for (genvar l = 0; l < MAXL; l++) begin : g_lane
      if (l < NL) begin : g_on
        smac_lane_mul #(.W(W), .AW(AW)) u_mul (
          .a_i(in_a[l*W +: W]), .b_i(in_b[l*W +: W]),
          .sgn_i(in_signed), .frac_i(in_frac), .sat_i(in_sat),
          .prod_o(prod_m[l*AW +: AW]));
        smac_lane_acc #(.AW(AW)) u_acc (
          .acc_i(acc_q[l*AW +: AW]), .prod_i(s1_prod[l*AW +: AW]),
          .sgn_i(s1_ctrl.sgn), .sat_i(s1_ctrl.sat),
          .clr_i(s1_ctrl.clr), .add_i(s1_ctrl.acc_en),
          .acc_o(acc_m[l*AW +: AW]), .ovf_o(ovf_m[l]));
      end else begin : g_off
        assign ovf_m[l] = 1'b0;
      end
    end
    assign prod_all[m] = prod_m;
    assign acc_all[m]  = acc_m;
    assign ovf_all[m]  = ovf_m;
  end

  always_comb begin
    prod_sel = prod_all[split_idx(in_ctrl.mode)];
    acc_sel  = acc_all[split_idx(s1_ctrl.mode)];
    ovf_sel  = ovf_all[split_idx(s1_ctrl.mode)];
  end

  // stage one: widened products and their control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_ctrl <= '0;
      s1_prod <= '0;
    end else if (advance) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_ctrl <= in_ctrl;
        s1_prod <= prod_sel;
      end
    end
  end

  // stage two: accumulators and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      acc_q <= '0;
      ovf_q <= '0;
    end else if (advance) begin
      out_v <= s1_v;
      if (s1_v) begin
        acc_q <= acc_sel;
        ovf_q <= (s1_ctrl.clr ? '0 : ovf_q) | ovf_sel;
      end
    end
  end

  assign out_valid = out_v;
  assign acc_o     = acc_q;
  assign ovf_o     = ovf_q;

  // R10: an accepted beat followed by a free cycle lands two cycles later
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  // R11: a stalled result stays put
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_o) && $stable(ovf_o)));

  // R11: input is refused only while a result waits on the consumer
  assert_refuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R8: flags drop only through a clearing beat
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q != '0) && !(s1_v && advance && s1_ctrl.clr))
      |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

endmodule

// File: tb/smac_unit_test.sv
`timescale 1ns/1ps
module smac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic [1:0]  in_mode = '0;
  logic        in_signed = 1'b0, in_frac = 1'b0, in_sat = 1'b0;
  logic        in_clr = 1'b0, in_acc_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [79:0] acc_o;
  logic [3:0]  ovf_o;

  int n_run = 0, n_fail = 0;
  logic [79:0] exp_acc = '0;
  logic [3:0]  exp_ovf = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  smac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .in_signed(in_signed),
    .in_frac(in_frac), .in_sat(in_sat), .in_clr(in_clr), .in_acc_en(in_acc_en),
    .out_valid(out_valid), .out_ready(out_ready), .acc_o(acc_o), .ovf_o(ovf_o));

  function automatic logic [31:0] next_rng(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  // arithmetic reference for one lane, written from the requirements
  function automatic void ref_lane(input logic [127:0] acc, input logic [31:0] a, b,
      input int w, aw, input bit sg, fr, st, cl, en,
      output logic [127:0] nacc, output bit ov);
    logic signed [131:0] one, av, bv, p, base, s, mx, mn, msk;
    one = 132'sd1;
    msk = (one <<< w) - one;
    av = {100'b0, a} & msk;  bv = {100'b0, b} & msk;
    if (sg && av[w-1]) av = av - (one <<< w);
    if (sg && bv[w-1]) bv = bv - (one <<< w);
    p = av * bv;
    if (sg && fr) p = p * 2;
    if (sg && fr && st && p == (one <<< (2*w-1))) p = p - one;
    base = {4'b0, acc} & ((one <<< aw) - one);
    if (sg && base[aw-1]) base = base - (one <<< aw);
    if (cl) base = '0;
    ov = 1'b0;
    if (en) begin
      s  = base + p;
      mx = sg ? (one <<< (aw-1)) - one : (one <<< aw) - one;
      mn = sg ? -(one <<< (aw-1)) : '0;
      ov = (s > mx) || (s < mn);
      if (ov && st) s = (s > mx) ? mx : mn;
    end else s = base;
    s = s & ((one <<< aw) - one);
    nacc = s[127:0];
  endfunction

  task automatic model_step(input logic [31:0] a, b, input logic [1:0] mode,
      input bit sg, fr, st, cl, en);
    int mi = (mode == 2'd0) ? 0 : (mode == 2'd1) ? 1 : 2;
    int nl = 1 << mi, w = 32 >> mi, aw = 80 >> mi;
    logic [3:0] nov = cl ? 4'b0 : exp_ovf;
    for (int l = 0; l < nl; l++) begin
      logic [127:0] la, na;
      bit ov;
      la = '0;
      for (int k = 0; k < aw; k++) la[k] = exp_acc[l*aw + k];
      ref_lane(la, a >> (l*w), b >> (l*w), w, aw, sg, fr, st, cl, en, na, ov);
      for (int k = 0; k < aw; k++) exp_acc[l*aw + k] = na[k];
      if (ov) nov[l] = 1'b1;
    end
    exp_ovf = nov;
  endtask

  task automatic check_out(input string tag);
    n_run++;
    if (!out_valid || acc_o !== exp_acc || ovf_o !== exp_ovf) begin
      n_fail++;
      $display("FAIL %s: valid=%0b acc=%h ovf=%b expected valid=1 acc=%h ovf=%b",
               tag, out_valid, acc_o, ovf_o, exp_acc, exp_ovf);
    end
  endtask

  // drive one beat, let it through the two stages, check in cycle i+2
  task automatic beat(input logic [31:0] a, b, input logic [1:0] mode,
      input bit sg, fr, st, cl, en, input string tag, input bit chk_gap = 1'b0);
    in_a = a; in_b = b; in_mode = mode; in_signed = sg; in_frac = fr;
    in_sat = st; in_clr = cl; in_acc_en = en; in_valid = 1'b1;
    model_step(a, b, mode, sg, fr, st, cl, en);
    @(negedge clk);
    in_valid = 1'b0;
    if (chk_gap) begin
      n_run++;
      if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R10: out_valid=%0b in cycle i+1, expected 0", out_valid);
      end
    end
    @(negedge clk);
    check_out(tag);
  endtask

  logic [31:0] v8  [7] = '{32'h00, 32'h01, 32'h7F, 32'h80, 32'hFF, 32'h81, 32'h40};
  logic [31:0] v16 [7] = '{32'h0000, 32'h0001, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h8001, 32'h4000};
  logic [31:0] v32 [7] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                           32'h8000_0001, 32'h4000_0000};

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    n_run++;
    if (out_valid !== 1'b0 || acc_o !== '0 || ovf_o !== '0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R12: valid=%0b acc=%h ovf=%b ready=%0b expected 0/0/0/1",
               out_valid, acc_o, ovf_o, in_ready);
    end

    // R10: latency, with the gap cycle observed
    beat(32'h0302_0105, 32'h0101_0203, 2'd2, 0, 0, 0, 1, 1, "R10", 1'b1);

    // R1 R3 R4 R5: corner sweeps for each lane width, all format combinations
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++) begin
          logic [31:0] a8, b8, a16, b16;
          a8  = {v8[i][7:0], v8[j][7:0], v8[(i+j)%7][7:0], v8[(i+3)%7][7:0]};
          b8  = {v8[j][7:0], v8[(i+2)%7][7:0], v8[i][7:0], v8[(j+5)%7][7:0]};
          a16 = {v16[j][15:0], v16[i][15:0]};
          b16 = {v16[(i+j)%7][15:0], v16[j][15:0]};
          beat(a8, b8, 2'd2, c[0], c[1], c[2], 1, 1, "R1 R3 R4 R5 lanes8");
          beat(b8, a8, 2'd2, c[0], c[1], c[2], 0, 1, "R3 R4 accumulate8");
          beat(a16, b16, 2'd1, c[0], c[1], c[2], 1, 1, "R1 R3 R4 R5 lanes16");
          beat(v32[i], v32[j], 2'd0, c[0], c[1], c[2], 1, 1, "R1 R3 R4 R5 lane32");
          beat(v32[j], v32[i], 2'd0, c[0], c[1], c[2], 0, 1, "R2 accumulate32");
        end

    // R5: explicit minus-one squared, fractional signed, 16-bit lanes
    beat(32'h8000_8000, 32'h8000_8000, 2'd1, 1, 1, 1, 1, 1, "R5 clamp");
    beat(32'h8000_8000, 32'h8000_8000, 2'd1, 1, 1, 0, 1, 1, "R5 no clamp");

    // R1: code 3 behaves as four 8-bit lanes
    beat(32'hF07F_8001, 32'h8102_7FFF, 2'd3, 1, 0, 0, 1, 1, "R1 code3");

    // R6 R8: signed saturation in 8-bit lanes
    beat(32'h8080_7F80, 32'h8080_7F7F, 2'd2, 1, 0, 1, 1, 1, "R6 start");
    for (int k = 0; k < 40; k++)
      beat(32'h8080_7F80, 32'h8080_7F7F, 2'd2, 1, 0, 1, 0, 1, "R6 R8 signed sat8");
    // R7 R8: wrapping in 8-bit lanes
    for (int k = 0; k < 40; k++)
      beat(32'h8080_7F80, 32'h807F_7F7F, 2'd2, 1, 0, 0, (k == 0), 1, "R7 R8 wrap8");
    // R9: enable low ignores the product, flags kept
    beat(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1, 0, 0, 0, 0, "R9 ignored");
    // R8 R9: clear without enable zeroes lanes and flags
    beat(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1, 0, 0, 1, 0, "R8 R9 clear");
    // R6 R7: unsigned 16-bit lanes, saturating then wrapping
    for (int k = 0; k < 300; k++)
      beat(32'hFFFF_FFFF, 32'hFFFF_FFF0, 2'd1, 0, 0, 1, (k == 0), 1, "R6 unsigned sat16");
    // R8: flags of lanes unused in one-lane mode are kept
    beat(32'h0000_0003, 32'h0000_0005, 2'd0, 0, 0, 0, 0, 1, "R8 unused lanes");
    for (int k = 0; k < 300; k++)
      beat(32'hFFFF_FFFF, 32'hFFFF_FFF0, 2'd1, 0, 0, 0, (k == 0), 1, "R7 unsigned wrap16");
    for (int k = 0; k < 300; k++)
      beat(32'h8000_8000, 32'h8000_8000, 2'd1, 1, 1, (k < 150), (k == 0 || k == 150), 1,
           "R6 R7 signed frac16");

    // R2 R7 R9: pseudo-random sequences across all modes
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ra, rb, rc;
      rng = next_rng(rng); ra = rng;
      rng = next_rng(rng); rb = rng;
      rng = next_rng(rng); rc = rng;
      beat(ra, rb, rc[1:0], rc[2], rc[3], rc[4], (rc[9:6] == 4'd0), (rc[11:10] != 2'd0),
           "R2 R7 R9 random");
    end

    // R11: back-pressure holds the result and refuses input
    out_ready = 1'b1;
    in_a = 32'h0011_0022; in_b = 32'h0003_0004; in_mode = 2'd1; in_signed = 1'b0;
    in_frac = 1'b0; in_sat = 1'b0; in_clr = 1'b1; in_acc_en = 1'b1; in_valid = 1'b1;
    model_step(in_a, in_b, 2'd1, 0, 0, 0, 1, 1);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    in_a = 32'h0100_0100; in_b = 32'h0002_0002; in_clr = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check_out("R11 held");
      n_run++;
      if (in_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R11: in_ready=%0b during stall, expected 0", in_ready);
      end
      @(negedge clk);
    end
    check_out("R11 held");
    out_ready = 1'b1;
    model_step(32'h0100_0100, 32'h0002_0002, 2'd1, 0, 0, 0, 0, 1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_out("R11 released");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule